// File: doc/BRIEF.md
# Configuration Window Bridge

This block lets a host reach the configuration space of downstream devices through two registers. A 64-bit address register holds an enable flag, a bus number, a device/function number and a dword-aligned register offset. A 4-byte data window carries the data. A data-window access is turned into one configuration read or write toward the target port. The low two bits of the window access give the byte position within the dword.

The data window is little-endian inside a big-endian register space. Two-byte and four-byte values are therefore byte-reversed in both directions, and single bytes pass through unchanged. The bus and device/function fields are driven to the target at all times as a lookup. The target answers combinationally whether a device is present there and whether it has the extended (4096-byte) configuration space or the conventional 256-byte one.

An access that cannot be made (disabled, no device, out of range, bad size) produces no target request. It is answered one cycle later with all ones. Only one transaction is open at a time.

Top module: `cfg_window_bridge`

## Requirements
- R1: After reset the address register reads as zero, `host_rsp_o` and `tgt_req_o` are low.
- R2: An 8-byte write at the address-register offset (default 0x130) stores the 64-bit value. An 8-byte read there returns it. Both are answered one cycle after the request.
- R3: When bit 63 of the address register is 0, a data-window read returns 64'hFFFF_FFFF_FFFF_FFFF and a data-window write issues no target request.
- R4: `tgt_bus_o` always equals address-register bits 59:52 and `tgt_devfn_o` always equals bits 51:44.
- R5: The target register offset is address-register bits 43:34 followed by the two low bits of the host access offset. Bits 33:32 of the register are ignored.
- R6: Any host offset whose bits above bit 1 match the data-window offset (default 0x140, so 0x140 to 0x143) is a window access. Offsets 0x13C and 0x144 are not.
- R7: Host sizes 1, 2 and 4 are coded as byte counts. The byte lanes `tgt_be_o` are the low size bits shifted left by the byte offset. Write data is the low size bytes of `host_wdata_i` reversed in order, placed at the same lanes. Read data is the lane bytes taken from `tgt_rdata_i`, reversed, and zero-extended.
- R8: When `tgt_express_i` is low and the target offset is 256 or more, a read returns all ones and a write issues no request. Offset 255 is still allowed. With `tgt_express_i` high, every 12-bit offset is allowed.
- R9: When `tgt_present_i` is low, the window behaves as in R3.
- R10: `tgt_req_o` rises one cycle after an accepted window request and holds its fields until `tgt_ready_i` is sampled high. `host_rsp_o` pulses in the cycle after that. Write responses carry all ones.
- R11: A window access whose size is not 1, 2 or 4 is answered with all ones and no request. A write at the address-register offset whose size is not 8 leaves the register unchanged.
- R12: A request at any other offset is answered one cycle later with all ones and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req_i | input | 1 | Host request strobe (ignored while a target access is open) |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_off_i | input | OFF_W | Host register byte offset |
| host_size_i | input | 4 | Access size in bytes (1, 2, 4, 8) |
| host_wdata_i | input | 64 | Host write data, right-aligned |
| host_rsp_o | output | 1 | One-cycle response pulse |
| host_rdata_o | output | 64 | Response data |
| tgt_bus_o | output | 8 | Decoded bus number (continuous lookup) |
| tgt_devfn_o | output | 8 | Decoded device/function (continuous lookup) |
| tgt_present_i | input | 1 | A device answers at the lookup bus/devfn |
| tgt_express_i | input | 1 | That device has the 4096-byte space |
| tgt_req_o | output | 1 | Target request, held until ready |
| tgt_we_o | output | 1 | Target write |
| tgt_reg_o | output | 12 | Configuration byte offset |
| tgt_size_o | output | 3 | Size in bytes |
| tgt_be_o | output | 4 | Byte lanes within the dword |
| tgt_wdata_o | output | 32 | Lane-aligned write data |
| tgt_ready_i | input | 1 | Target completes the request |
| tgt_rdata_i | input | 32 | Lane-aligned read data |

## Verification
Results that need no target arrive in the cycle after the host strobe: the address-register value, and the all-ones answers for blocked or foreign accesses. A target request also appears in that cycle. The host response comes exactly one cycle after the edge that samples `tgt_ready_i`. The bench drives every input on a falling edge and samples on the next falling edge, so each check reads the output of exactly one rising edge. Each of those checks lands in the cycle where its result is due, with the target holding ready off for zero to three cycles. The lookup outputs are compared against the bench's own copy of the address register on every clock.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int REG_W     = 64;
  localparam int EN_BIT    = 63;
  localparam int BUS_LSB   = 52;
  localparam int DF_LSB    = 44;
  localparam int REG_LSB   = 32;
  localparam int ID_W      = 8;
  localparam int CFG_OFF_W = 12;
  localparam int DW_OFF_W  = CFG_OFF_W - 2;
  localparam int WIN_BYTES = 4;
  localparam int WIN_W     = 8 * WIN_BYTES;
  localparam int LANE_W    = $clog2(WIN_BYTES);

  // little-endian window in a big-endian space: reverse the used bytes
  function automatic logic [WIN_W-1:0] swap_win(input logic [WIN_W-1:0] v,
                                                input logic [2:0] nbytes);
    case (nbytes)
      3'd2:    return {16'h0, v[7:0], v[15:8]};
      3'd4:    return {v[7:0], v[15:8], v[23:16], v[31:24]};
      default: return {24'h0, v[7:0]};
    endcase
  endfunction
endpackage

// File: rtl/cfgb_addr_reg.sv
module cfgb_addr_reg
  import cfgb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    q,
  output logic                en,
  output logic [ID_W-1:0]     bus,
  output logic [ID_W-1:0]     devfn,
  output logic [DW_OFF_W-1:0] dw_off
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wdata;
  end

  assign en     = q[EN_BIT];
  assign bus    = q[BUS_LSB +: ID_W];
  assign devfn  = q[DF_LSB +: ID_W];
  assign dw_off = q[REG_LSB + 2 +: DW_OFF_W];
endmodule

// File: rtl/cfgb_lane.sv
module cfgb_lane
  import cfgb_pkg::*;
(
  input  logic [LANE_W-1:0]    byte_off,
  input  logic [2:0]           nbytes,
  input  logic [WIN_W-1:0]     host_data,
  input  logic [WIN_W-1:0]     tgt_data,
  output logic [WIN_BYTES-1:0] be,
  output logic [WIN_W-1:0]     wlanes,
  output logic [WIN_W-1:0]     rvalue
);
  logic [WIN_BYTES-1:0] base_mask;
  logic [LANE_W+2:0]    bit_sh;

  always_comb begin
    case (nbytes)
      3'd2:    base_mask = 4'b0011;
      3'd4:    base_mask = 4'b1111;
      default: base_mask = 4'b0001;
    endcase
    bit_sh = {byte_off, 3'b000};
    be     = base_mask << byte_off;
    wlanes = swap_win(host_data, nbytes) << bit_sh;
    rvalue = swap_win(tgt_data >> bit_sh, nbytes);
  end
endmodule

// File: rtl/cfgb_ctrl.sv
module cfgb_ctrl
  import cfgb_pkg::*;
#(
  parameter int                OFF_W          = 16,
  parameter logic [OFF_W-1:0]  ADDR_REG_OFF   = 16'h0130,
  parameter logic [OFF_W-1:0]  DATA_WIN_OFF   = 16'h0140,
  parameter int                CONV_CFG_BYTES = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_req,
  input  logic                 host_we,
  input  logic [OFF_W-1:0]     host_off,
  input  logic [3:0]           host_size,
  input  logic [REG_W-1:0]     addr_q,
  input  logic                 en,
  input  logic                 present,
  input  logic                 express,
  input  logic [DW_OFF_W-1:0]  dw_off,
  input  logic [WIN_BYTES-1:0] be,
  input  logic [WIN_W-1:0]     wlanes,
  input  logic [WIN_W-1:0]     rvalue,
  input  logic                 tgt_ready,
  output logic                 addr_wr,
  output logic                 host_rsp,
  output logic [REG_W-1:0]     host_rdata,
  output logic                 tgt_req,
  output logic                 tgt_we,
  output logic [CFG_OFF_W-1:0] tgt_reg,
  output logic [2:0]           tgt_size,
  output logic [WIN_BYTES-1:0] tgt_be,
  output logic [WIN_W-1:0]     tgt_wdata
);
  localparam logic [CFG_OFF_W:0] CONV_LIMIT = CONV_CFG_BYTES[CFG_OFF_W:0];
  localparam logic [REG_W-1:0]   ALL_ONES   = '1;

  logic                 accept, win_hit, addr_hit, size_ok, in_range, go;
  logic [CFG_OFF_W-1:0] reg_off;

  always_comb begin
    accept   = host_req && !tgt_req;
    win_hit  = host_off[OFF_W-1:LANE_W] == DATA_WIN_OFF[OFF_W-1:LANE_W];
    addr_hit = (host_off == ADDR_REG_OFF) && (host_size == 4'd8);
    size_ok  = (host_size == 4'd1) || (host_size == 4'd2) || (host_size == 4'd4);
    reg_off  = {dw_off, host_off[LANE_W-1:0]};
    in_range = express || ({1'b0, reg_off} < CONV_LIMIT);
    go       = en && present && size_ok && in_range;
    addr_wr  = accept && host_we && addr_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rsp   <= 1'b0;
      host_rdata <= '0;
      tgt_req    <= 1'b0;
      tgt_we     <= 1'b0;
      tgt_reg    <= '0;
      tgt_size   <= '0;
      tgt_be     <= '0;
      tgt_wdata  <= '0;
    end else begin
      host_rsp <= 1'b0;
      if (tgt_req) begin
        if (tgt_ready) begin
          tgt_req    <= 1'b0;
          host_rsp   <= 1'b1;
          host_rdata <= tgt_we ? ALL_ONES : {{(REG_W-WIN_W){1'b0}}, rvalue};
        end
      end else if (accept) begin
        if (win_hit && go) begin
          tgt_req   <= 1'b1;
          tgt_we    <= host_we;
          tgt_reg   <= reg_off;
          tgt_size  <= host_size[2:0];
          tgt_be    <= be;
          tgt_wdata <= wlanes;
        end else begin
          host_rsp   <= 1'b1;
          host_rdata <= (!win_hit && addr_hit && !host_we) ? addr_q : ALL_ONES;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge
  import cfgb_pkg::*;
#(
  parameter int                OFF_W          = 16,
  parameter logic [OFF_W-1:0]  ADDR_REG_OFF   = 16'h0130,
  parameter logic [OFF_W-1:0]  DATA_WIN_OFF   = 16'h0140,
  parameter int                CONV_CFG_BYTES = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_req_i,
  input  logic                 host_we_i,
  input  logic [OFF_W-1:0]     host_off_i,
  input  logic [3:0]           host_size_i,
  input  logic [REG_W-1:0]     host_wdata_i,
  output logic                 host_rsp_o,
  output logic [REG_W-1:0]     host_rdata_o,
  output logic [ID_W-1:0]      tgt_bus_o,
  output logic [ID_W-1:0]      tgt_devfn_o,
  input  logic                 tgt_present_i,
  input  logic                 tgt_express_i,
  output logic                 tgt_req_o,
  output logic                 tgt_we_o,
  output logic [CFG_OFF_W-1:0] tgt_reg_o,
  output logic [2:0]           tgt_size_o,
  output logic [WIN_BYTES-1:0] tgt_be_o,
  output logic [WIN_W-1:0]     tgt_wdata_o,
  input  logic                 tgt_ready_i,
  input  logic [WIN_W-1:0]     tgt_rdata_i
);
  logic [REG_W-1:0]     cfg_addr_q;
  logic                 cfg_en;
  logic [DW_OFF_W-1:0]  cfg_dw_off;
  logic                 addr_wr;
  logic [LANE_W-1:0]    lane_off;
  logic [2:0]           lane_size;
  logic [WIN_BYTES-1:0] lane_be;
  logic [WIN_W-1:0]     lane_wdata, lane_rvalue;

  cfgb_addr_reg u_addr (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (addr_wr),
    .wdata  (host_wdata_i),
    .q      (cfg_addr_q),
    .en     (cfg_en),
    .bus    (tgt_bus_o),
    .devfn  (tgt_devfn_o),
    .dw_off (cfg_dw_off)
  );

  // new request picks lanes from host inputs; open request from held fields
  assign lane_off  = tgt_req_o ? tgt_reg_o[LANE_W-1:0] : host_off_i[LANE_W-1:0];
  assign lane_size = tgt_req_o ? tgt_size_o : host_size_i[2:0];

  cfgb_lane u_lane (
    .byte_off  (lane_off),
    .nbytes    (lane_size),
    .host_data (host_wdata_i[WIN_W-1:0]),
    .tgt_data  (tgt_rdata_i),
    .be        (lane_be),
    .wlanes    (lane_wdata),
    .rvalue    (lane_rvalue)
  );

  cfgb_ctrl #(
    .OFF_W          (OFF_W),
    .ADDR_REG_OFF   (ADDR_REG_OFF),
    .DATA_WIN_OFF   (DATA_WIN_OFF),
    .CONV_CFG_BYTES (CONV_CFG_BYTES)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .host_req   (host_req_i),
    .host_we    (host_we_i),
    .host_off   (host_off_i),
    .host_size  (host_size_i),
    .addr_q     (cfg_addr_q),
    .en         (cfg_en),
    .present    (tgt_present_i),
    .express    (tgt_express_i),
    .dw_off     (cfg_dw_off),
    .be         (lane_be),
    .wlanes     (lane_wdata),
    .rvalue     (lane_rvalue),
    .tgt_ready  (tgt_ready_i),
    .addr_wr    (addr_wr),
    .host_rsp   (host_rsp_o),
    .host_rdata (host_rdata_o),
    .tgt_req    (tgt_req_o),
    .tgt_we     (tgt_we_o),
    .tgt_reg    (tgt_reg_o),
    .tgt_size   (tgt_size_o),
    .tgt_be     (tgt_be_o),
    .tgt_wdata  (tgt_wdata_o)
  );
endmodule

// File: rtl/cfg_window_bridge_chk.sv
module cfg_window_bridge_chk #(
  parameter int CONV_CFG_BYTES = 256
) (
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic        host_rsp,
  input logic        tgt_req,
  input logic        tgt_ready,
  input logic        tgt_present,
  input logic        tgt_express,
  input logic [11:0] tgt_reg,
  input logic [2:0]  tgt_size,
  input logic [3:0]  tgt_be
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    tgt_req && !tgt_ready |=> tgt_req && $stable(tgt_reg) && $stable(tgt_be));

  assert_rsp_after_ready_R10: assert property (@(posedge clk) disable iff (rst)
    tgt_req && tgt_ready |=> host_rsp && !tgt_req);

  assert_single_open_R10: assert property (@(posedge clk) disable iff (rst)
    !(host_rsp && tgt_req));

  assert_lanes_R7: assert property (@(posedge clk) disable iff (rst)
    tgt_req |-> $countones(tgt_be) == int'(tgt_size));

  assert_limit_R8: assert property (@(posedge clk) disable iff (rst)
    tgt_req && !tgt_express |-> int'(tgt_reg) < CONV_CFG_BYTES);

  // also covers R9: no request without a present device
  assert_enabled_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(tgt_req) |-> en && tgt_present);
endmodule

bind cfg_window_bridge cfg_window_bridge_chk #(.CONV_CFG_BYTES(CONV_CFG_BYTES)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (cfg_en),
  .host_rsp    (host_rsp_o),
  .tgt_req     (tgt_req_o),
  .tgt_ready   (tgt_ready_i),
  .tgt_present (tgt_present_i),
  .tgt_express (tgt_express_i),
  .tgt_reg     (tgt_reg_o),
  .tgt_size    (tgt_size_o),
  .tgt_be      (tgt_be_o)
);

// File: tb/test_cfg_window_bridge.sv
`timescale 1ns/1ps
module test_cfg_window_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req_i = 1'b0, host_we_i = 1'b0;
  logic [15:0] host_off_i = '0;
  logic [3:0]  host_size_i = '0;
  logic [63:0] host_wdata_i = '0;
  logic        host_rsp_o;
  logic [63:0] host_rdata_o;
  logic [7:0]  tgt_bus_o, tgt_devfn_o;
  logic        tgt_present_i, tgt_express_i;
  logic        tgt_req_o, tgt_we_o;
  logic [11:0] tgt_reg_o;
  logic [2:0]  tgt_size_o;
  logic [3:0]  tgt_be_o;
  logic [31:0] tgt_wdata_o;
  logic        tgt_ready_i = 1'b0;
  logic [31:0] tgt_rdata_i = '0;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  always #10 clk = ~clk;

  // target model: bus 7F empty, buses below 0x10 have the extended space
  assign tgt_present_i = (tgt_bus_o != 8'h7F);
  assign tgt_express_i = (tgt_bus_o < 8'h10);

  cfg_window_bridge i_cfg_window_bridge (.*);

  int          checks = 0, fails = 0;
  bit          done = 1'b0;
  logic [63:0] model_addr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(tgt_bus_o == model_addr[59:52], "R4", "bus lookup", tgt_bus_o, model_addr[59:52]);
    chk(tgt_devfn_o == model_addr[51:44], "R4", "devfn lookup", tgt_devfn_o, model_addr[51:44]);
  endtask

  function automatic logic [63:0] mk(input bit en, input logic [7:0] bus,
                                     input logic [7:0] df, input logic [11:0] r);
    return {en, 3'b000, bus, df, r, 32'h0};
  endfunction

  function automatic logic [31:0] sw_ref(input logic [31:0] v, input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[8*i +: 8] = v[8*(n-1-i) +: 8];
    return r;
  endfunction

  // access answered without the target
  task automatic imm(input bit we, input logic [15:0] off, input logic [3:0] sz,
                     input logic [63:0] wd, input logic [63:0] exp, input string req);
    host_req_i = 1'b1; host_we_i = we; host_off_i = off;
    host_size_i = sz; host_wdata_i = wd;
    if (we && off == 16'h0130 && sz == 4'd8) model_addr = wd;
    step();
    host_req_i = 1'b0;
    chk(host_rsp_o == 1'b1, req, "immediate rsp", 64'(host_rsp_o), 64'd1);
    chk(tgt_req_o == 1'b0, req, "no target request", 64'(tgt_req_o), 64'd0);
    chk(host_rdata_o == exp, req, "rdata", host_rdata_o, exp);
  endtask

  // access forwarded to the target
  task automatic tgt(input bit we, input logic [15:0] off, input int n,
                     input logic [31:0] wd, input int dly, input logic [31:0] td,
                     input string req);
    logic [11:0] reg_e = {model_addr[43:34], off[1:0]};
    logic [3:0]  be_e  = 4'(((1 << n) - 1) << off[1:0]);
    logic [31:0] wl_e  = sw_ref(wd, n) << (8 * off[1:0]);
    logic [63:0] rd_e  = we ? ONES : {32'h0, sw_ref(td >> (8 * off[1:0]), n)};
    host_req_i = 1'b1; host_we_i = we; host_off_i = off;
    host_size_i = 4'(n); host_wdata_i = {32'h0, wd};
    step();
    host_req_i = 1'b0;
    chk(tgt_req_o == 1'b1, "R10", "request raised", 64'(tgt_req_o), 64'd1);
    chk(tgt_we_o == we, req, "direction", 64'(tgt_we_o), 64'(we));
    chk(tgt_reg_o == reg_e, "R5", "target offset", 64'(tgt_reg_o), 64'(reg_e));
    chk(tgt_size_o == 3'(n), req, "size", 64'(tgt_size_o), 64'(n));
    chk(tgt_be_o == be_e, "R7", "byte lanes", 64'(tgt_be_o), 64'(be_e));
    if (we) chk(tgt_wdata_o == wl_e, "R7", "write lanes", 64'(tgt_wdata_o), 64'(wl_e));
    chk(host_rsp_o == 1'b0, "R10", "no early rsp", 64'(host_rsp_o), 64'd0);
    for (int i = 0; i < dly; i++) begin
      step();
      chk(tgt_req_o == 1'b1 && host_rsp_o == 1'b0, "R10", "hold while not ready",
          64'({tgt_req_o, host_rsp_o}), 64'h2);
    end
    tgt_ready_i = 1'b1; tgt_rdata_i = td;
    step();
    tgt_ready_i = 1'b0;
    chk(host_rsp_o == 1'b1, "R10", "rsp after ready", 64'(host_rsp_o), 64'd1);
    chk(tgt_req_o == 1'b0, "R10", "request dropped", 64'(tgt_req_o), 64'd0);
    chk(host_rdata_o == rd_e, req, "response data", host_rdata_o, rd_e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(host_rsp_o == 1'b0 && tgt_req_o == 1'b0, "R1", "idle in reset",
        64'({host_rsp_o, tgt_req_o}), 64'd0);
    rst = 1'b0;
    step();
    imm(0, 16'h0130, 8, 0, 64'h0, "R1");

    imm(1, 16'h0130, 8, mk(0, 8'h03, 8'h21, 12'h010), ONES, "R2");
    imm(0, 16'h0130, 8, 0, mk(0, 8'h03, 8'h21, 12'h010), "R2");
    imm(0, 16'h0140, 4, 0, ONES, "R3");
    imm(1, 16'h0140, 4, 64'h1, ONES, "R3");

    imm(1, 16'h0130, 8, mk(1, 8'h05, 8'h08, 12'h010), ONES, "R2");
    tgt(0, 16'h0140, 4, 0, 2, 32'h1122_3344, "R7");
    chk(sw_ref(32'h1122_3344, 4) == 32'h4433_2211, "R7", "swap32 reference",
        64'(sw_ref(32'h1122_3344, 4)), 64'h4433_2211);
    tgt(0, 16'h0142, 2, 0, 0, 32'hAABB_CCDD, "R6");
    tgt(0, 16'h0143, 1, 0, 1, 32'h5A00_0000, "R5");
    tgt(1, 16'h0141, 2, 32'h0000_1234, 0, 0, "R7");
    tgt(1, 16'h0140, 4, 32'hDEAD_BEEF, 3, 0, "R10");

    imm(1, 16'h0130, 8, mk(1, 8'h20, 8'h10, 12'h103), ONES, "R5");
    imm(0, 16'h0140, 4, 0, ONES, "R8");
    imm(1, 16'h0141, 1, 64'hAB, ONES, "R8");
    imm(1, 16'h0130, 8, mk(1, 8'h20, 8'h10, 12'h0FE), ONES, "R8");
    tgt(0, 16'h0143, 1, 0, 0, 32'h7700_0000, "R8");
    imm(1, 16'h0130, 8, mk(1, 8'h02, 8'h10, 12'hFFF), ONES, "R8");
    tgt(1, 16'h0143, 1, 32'h0000_00A5, 0, 0, "R8");

    imm(1, 16'h0130, 8, mk(1, 8'h7F, 8'h00, 12'h000), ONES, "R9");
    imm(0, 16'h0140, 4, 0, ONES, "R9");
    imm(1, 16'h0140, 4, 64'h5, ONES, "R9");

    imm(1, 16'h0130, 8, mk(1, 8'h05, 8'h08, 12'h010), ONES, "R2");
    imm(0, 16'h0140, 3, 0, ONES, "R11");
    imm(1, 16'h0130, 4, mk(0, 8'h44, 8'h44, 12'h444), ONES, "R11");
    imm(0, 16'h0130, 8, 0, mk(1, 8'h05, 8'h08, 12'h010), "R11");

    imm(0, 16'h0200, 8, 0, ONES, "R12");
    imm(1, 16'h0200, 8, 64'h0, ONES, "R12");
    imm(0, 16'h0130, 8, 0, mk(1, 8'h05, 8'h08, 12'h010), "R12");

    imm(0, 16'h0144, 4, 0, ONES, "R6");
    imm(0, 16'h013C, 4, 0, ONES, "R6");

    step();
    chk(host_rsp_o == 1'b0 && tgt_req_o == 1'b0, "R10", "quiet after traffic",
        64'({host_rsp_o, tgt_req_o}), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule